// File: doc/BRIEF.md
# Idle Timer and Power-Mode Controller

This block keeps track of the power mode of a small microcontroller: normal run, a light sleep (IDLE) in which only the CPU clock is stopped, and a deep sleep (HALT) in which every clock enable is dropped. It contains a free-running idle timer that advances on an instruction-rate tick. One fixed bit of that timer acts as the automatic alarm for leaving IDLE. Each change of value on that bit also raises a software-visible timer pending flag. That flag, together with an interrupt enable bit, drives the timer interrupt request.

The CPU signals mode entry with single-cycle strobes. An external pin wake unit supplies two signals: a wake request, and a status line saying that some wake bit is both enabled and pending. A separate CAN wake line can also end a sleep. After any exit the block holds the CPU clock off for a short resynchronisation gap. It then pulses a resume strobe in the first run cycle. Software reads and writes the pending flag and the enable bit through a two-bit register port.

Top module: `pm_ctrl`

## Requirements
- R1: After reset the mode is run (`mode_o` = 0), the pending flag, enable bit and resume strobe are 0, the CPU clock enable is 1, and the idle timer is 0.
- R2: The idle timer advances by one on each cycle with `tick_i` high while the mode is run, IDLE or resync. It holds its value in HALT.
- R3: When timer bit TOG_BIT changes value, the pending flag is set. This happens every 2^TOG_BIT counted ticks. The flag stays set until a register write puts 0 in bit 0.
- R4: If a register write clears the pending flag in the same cycle as a toggle, the flag ends up set.
- R5: `reg_rdata_o` bit 0 is the pending flag and bit 1 is the interrupt enable. A write with `reg_we_i` loads both bits from `reg_wdata_i`. `tmr_irq_o` is high exactly when both bits are set.
- R6: In IDLE (`mode_o` = 1), a timer toggle moves the block to resync (`mode_o` = 3) on the next cycle.
- R7: `wake_i` or `can_wake_i` ends IDLE or HALT (`mode_o` = 2) and moves the block to resync. Both are ignored in run.
- R8: In run, `halt_req_i` is refused while `wake_armed_i` is high. The block stays in run unless `idle_req_i` is also high, in which case it enters IDLE.
- R9: Resync lasts RESYNC_CYC cycles. `resume_o` is then a one-cycle pulse in the first run cycle that follows.
- R10: `cpu_clk_en_o` is high only in run. `tmr_clk_en_o` is low only in HALT.
- R11: When `halt_req_i` and `idle_req_i` arrive together and the halt is not refused, HALT is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction-rate tick for the idle timer |
| idle_req_i | input | 1 | Strobe: enter IDLE |
| halt_req_i | input | 1 | Strobe: enter HALT |
| wake_i | input | 1 | Wake request from the pin wake unit |
| wake_armed_i | input | 1 | Some pin wake bit is enabled and pending |
| can_wake_i | input | 1 | Wake from CAN bus activity |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 2 | Write data: bit 0 pending, bit 1 enable |
| reg_rdata_o | output | 2 | Read data: bit 0 pending, bit 1 enable |
| tmr_pend_o | output | 1 | Timer pending flag |
| tmr_irq_o | output | 1 | Timer interrupt request |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| tmr_clk_en_o | output | 1 | Idle timer clock enable |
| resume_o | output | 1 | One-cycle strobe when execution resumes |
| mode_o | output | 2 | 0 run, 1 IDLE, 2 HALT, 3 resync |

## Verification
The hardest case to reach from the ports is a pending-flag clear that lands in exactly the cycle of a timer toggle. A second hard case is a toggle that falls due while the block sits in HALT with the tick still running. The bench keeps a reference count of the timer from the ticks it applies. With that count it times a directed write to the toggle cycle. It also parks the block in HALT one tick before a toggle, then checks that the toggle is held back until after the wake. Random phases mix strobes, wakes, armed status and writes so that sleep entries collide with toggles and resyncs.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_HALT   = 2'd2,
    PM_RESYNC = 2'd3
  } pm_mode_e;
endpackage

// File: rtl/idle_tmr.sv
module idle_tmr #(
  parameter int TOG_BIT = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic toggle_o
);
  localparam int CW = TOG_BIT + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  // the next increment flips the watched bit
  assign toggle_o = en_i && (&cnt_q[TOG_BIT-1:0]);

  // R2
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));

  // R3
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_o |=> (cnt_q[TOG_BIT] != $past(cnt_q[TOG_BIT])));
endmodule

// File: rtl/pm_regs.sv
module pm_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       toggle_i,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output logic       pend_o,
  output logic       en_o,
  output logic       irq_o
);
  logic pend_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (we_i) en_q <= wdata_i[1];
      if (toggle_i)  pend_q <= 1'b1;   // set beats a same-cycle clear
      else if (we_i) pend_q <= wdata_i[0];
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = pend_q & en_q;

  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_i |=> pend_q);

  // R3
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !we_i) |=> pend_q);
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import pm_pkg::*;
#(
  parameter int RESYNC_CYC = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     idle_req_i,
  input  logic     halt_req_i,
  input  logic     wake_i,
  input  logic     can_wake_i,
  input  logic     wake_armed_i,
  input  logic     toggle_i,
  output pm_mode_e mode_o,
  output logic     resume_o
);
  localparam int GAP_W = (RESYNC_CYC > 1) ? $clog2(RESYNC_CYC) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(RESYNC_CYC - 1);

  pm_mode_e        mode_q, mode_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic            resume_q;
  logic            ext_wake, gap_done;

  assign ext_wake = wake_i | can_wake_i;
  assign gap_done = (mode_q == PM_RESYNC) && (gap_q == GAP_LAST);

  always_comb begin
    mode_d = mode_q;
    gap_d  = gap_q;
    unique case (mode_q)
      PM_RUN: begin
        if (halt_req_i && !wake_armed_i) mode_d = PM_HALT;
        else if (idle_req_i)             mode_d = PM_IDLE;
      end
      PM_IDLE: if (ext_wake || toggle_i) begin
        mode_d = PM_RESYNC;
        gap_d  = '0;
      end
      PM_HALT: if (ext_wake) begin
        mode_d = PM_RESYNC;
        gap_d  = '0;
      end
      PM_RESYNC: begin
        if (gap_done) mode_d = PM_RUN;
        else          gap_d  = gap_q + 1'b1;
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= PM_RUN;
      gap_q    <= '0;
      resume_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      gap_q    <= gap_d;
      resume_q <= gap_done;
    end
  end

  assign mode_o   = mode_q;
  assign resume_o = resume_q;

  // R8
  halt_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_RUN && wake_armed_i) |=> mode_q != PM_HALT);

  // R7
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_HALT && !ext_wake) |=> mode_q == PM_HALT);

  // R6
  idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_IDLE && toggle_i) |=> mode_q == PM_RESYNC);

  // R9
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_q |-> (mode_q == PM_RUN && $past(mode_q) == PM_RESYNC));
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int TOG_BIT    = 12,
  parameter int RESYNC_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       idle_req_i,
  input  logic       halt_req_i,
  input  logic       wake_i,
  input  logic       wake_armed_i,
  input  logic       can_wake_i,
  input  logic       reg_we_i,
  input  logic [1:0] reg_wdata_i,
  output logic [1:0] reg_rdata_o,
  output logic       tmr_pend_o,
  output logic       tmr_irq_o,
  output logic       cpu_clk_en_o,
  output logic       tmr_clk_en_o,
  output logic       resume_o,
  output logic [1:0] mode_o
);
  pm_mode_e mode;
  logic     toggle, tmr_en, pend, en;

  assign tmr_en = tick_i && (mode != PM_HALT);

  idle_tmr #(.TOG_BIT(TOG_BIT)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tmr_en),
    .toggle_o (toggle)
  );

  pm_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .toggle_i (toggle),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .pend_o   (pend),
    .en_o     (en),
    .irq_o    (tmr_irq_o)
  );

  pm_fsm #(.RESYNC_CYC(RESYNC_CYC)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idle_req_i   (idle_req_i),
    .halt_req_i   (halt_req_i),
    .wake_i       (wake_i),
    .can_wake_i   (can_wake_i),
    .wake_armed_i (wake_armed_i),
    .toggle_i     (toggle),
    .mode_o       (mode),
    .resume_o     (resume_o)
  );

  assign reg_rdata_o  = {en, pend};
  assign tmr_pend_o   = pend;
  assign cpu_clk_en_o = (mode == PM_RUN);
  assign tmr_clk_en_o = (mode != PM_HALT);
  assign mode_o       = mode;

  // R10
  halt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) |-> !(cpu_clk_en_o || tmr_clk_en_o));
endmodule

// File: tb/sim_pm_ctrl.sv
`timescale 1ns/1ps
module sim_pm_ctrl;
  localparam int TB_TOG = 5;
  localparam int TB_RSY = 2;
  localparam int HALF   = 1 << TB_TOG;
  localparam int FULL   = 2 << TB_TOG;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, idle_r = 0, halt_r = 0, wake = 0, armed = 0, canw = 0, we = 0;
  logic [1:0] wd = 0, rd;
  logic pend, irq, cpu_en, tmr_en, resume;
  logic [1:0] mode;

  int n_chk = 0, n_bad = 0;
  int m_mode = 0, m_cnt = 0, m_gap = 0;
  bit m_pend = 0, m_en = 0, m_res = 0;

  always #2.5 clk = ~clk;

  pm_ctrl #(.TOG_BIT(TB_TOG), .RESYNC_CYC(TB_RSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .idle_req_i(idle_r),
    .halt_req_i(halt_r), .wake_i(wake), .wake_armed_i(armed), .can_wake_i(canw),
    .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rd), .tmr_pend_o(pend),
    .tmr_irq_o(irq), .cpu_clk_en_o(cpu_en), .tmr_clk_en_o(tmr_en),
    .resume_o(resume), .mode_o(mode));

  function automatic bit f_toggle(int md, int cnt, bit tk);
    return tk && md != 2 && (cnt % HALF) == HALF - 1;
  endfunction

  function automatic int f_next_mode(int md, int gap, bit tg);
    case (md)
      0: return (halt_r && !armed) ? 2 : (idle_r ? 1 : 0);
      1: return (wake || canw || tg) ? 3 : 1;
      2: return (wake || canw) ? 3 : 2;
      default: return (gap == TB_RSY - 1) ? 0 : 3;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit tg;
    int nm;
    tg = f_toggle(m_mode, m_cnt, tick);
    nm = f_next_mode(m_mode, m_gap, tg);
    m_res = (m_mode == 3 && m_gap == TB_RSY - 1);
    if (tick && m_mode != 2) m_cnt = (m_cnt + 1) % FULL;
    if (we) m_en = wd[1];
    if (tg) m_pend = 1'b1;
    else if (we) m_pend = wd[0];
    if (m_mode != 3 && nm == 3) m_gap = 0;
    else if (m_mode == 3 && nm == 3) m_gap++;
    m_mode = nm;
  endtask

  task automatic cmp_all();
    chk(int'(mode) == m_mode, "R7 mode", mode, m_mode);
    chk(pend == m_pend, "R3 pending", pend, m_pend);
    chk(rd == {m_en, m_pend}, "R5 rdata", rd, {m_en, m_pend});
    chk(irq == (m_en & m_pend), "R5 irq", irq, m_en & m_pend);
    chk(cpu_en == (m_mode == 0), "R10 cpu_en", cpu_en, m_mode == 0);
    chk(tmr_en == (m_mode != 2), "R10 tmr_en", tmr_en, m_mode != 2);
    chk(resume == m_res, "R9 resume", resume, m_res);
  endtask

  // inputs set at negedge, clock edge, then compare at next negedge
  task automatic cyc(bit tk, bit ir, bit hr, bit wk, bit ar, bit cw, bit w, logic [1:0] d);
    tick = tk; idle_r = ir; halt_r = hr; wake = wk; armed = ar; canw = cw; we = w; wd = d;
    @(posedge clk); #1;
    model_step();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle_cyc(bit tk);
    cyc(tk, 0, 0, 0, 0, 0, 0, 2'b00);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R1 reset state
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(pend == 1'b0 && rd == 2'b00, "R1 regs", rd, 0);
    chk(cpu_en == 1'b1 && resume == 1'b0, "R1 enables", cpu_en, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 count to first toggle in run
    for (int i = 0; i < HALF - 1; i++) idle_cyc(1);
    chk(pend == 1'b0, "R3 before toggle", pend, 0);
    idle_cyc(1);
    chk(pend == 1'b1, "R3 toggle sets pending", pend, 1);

    // R5 enable, irq
    cyc(0, 0, 0, 0, 0, 0, 1, 2'b11);
    chk(irq == 1'b1, "R5 irq on", irq, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 2'b10);
    chk(irq == 1'b0 && rd == 2'b10, "R5 clear", rd, 2);

    // R4 clear lands on toggle cycle
    while (m_cnt % HALF != HALF - 1) idle_cyc(1);
    cyc(1, 0, 0, 0, 0, 0, 1, 2'b10);
    chk(pend == 1'b1, "R4 set wins", pend, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 2'b00);

    // R7 wake ignored in run
    cyc(0, 0, 0, 1, 0, 1, 0, 2'b00);
    chk(mode == 2'd0, "R7 run ignores wake", mode, 0);

    // R8 halt refused while armed
    cyc(0, 0, 1, 0, 1, 0, 0, 2'b00);
    chk(mode == 2'd0, "R8 refused", mode, 0);
    cyc(0, 1, 1, 0, 1, 0, 0, 2'b00);
    chk(mode == 2'd1, "R8 refused halt falls to idle", mode, 1);

    // R6 idle exits on toggle, R9 gap and resume
    while (m_mode == 1) idle_cyc(1);
    chk(mode == 2'd3 && cpu_en == 1'b0, "R6 idle exit to resync", mode, 3);
    idle_cyc(0);
    chk(mode == 2'd3, "R9 gap second cycle", mode, 3);
    idle_cyc(0);
    chk(mode == 2'd0 && resume == 1'b1, "R9 resume pulse", resume, 1);
    idle_cyc(0);
    chk(resume == 1'b0, "R9 resume one cycle", resume, 0);

    // R11 both strobes -> halt; R2 frozen timer in halt
    cyc(0, 0, 0, 0, 0, 0, 1, 2'b00);
    while (m_cnt % HALF != HALF - 1) idle_cyc(1);
    cyc(0, 1, 1, 0, 0, 0, 0, 2'b00);
    chk(mode == 2'd2, "R11 halt wins", mode, 2);
    for (int i = 0; i < 20; i++) idle_cyc(1);
    chk(pend == 1'b0 && tmr_en == 1'b0, "R2 frozen in halt", pend, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 2'b00);
    chk(mode == 2'd3, "R7 can wake ends halt", mode, 3);
    idle_cyc(0); idle_cyc(0);
    idle_cyc(1);
    chk(pend == 1'b1, "R2 count resumes after halt", pend, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 20) == 0, ($urandom % 30) == 0,
          ($urandom % 40) == 0, ($urandom % 2) == 0, ($urandom % 60) == 0,
          ($urandom % 25) == 0, 2'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule